// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block chooses which frame of a fixed pool to evict when a new page has to be brought in. Each frame carries a single "recently used" flag, and a circular hand points at the next candidate. Hits on resident frames only raise the flag of the frame that was touched. They never start a replacement and never move the hand.

A victim is requested by holding `victim_req` high. While the request is up, the selector looks at the frame under the hand once per clock. A frame with its flag raised gets a second chance: its flag drops and the hand moves on. The first frame found with its flag low is granted in the same cycle, with `victim_frame` naming it. After a grant the hand steps past the victim, and the victim's flag is raised because the new page counts as used.

A separate `clr_all` pulse drops every flag at once, so that recency information can age out periodically. `victim_frame` always shows the current hand position and is meaningful as the victim only while `victim_gnt` is high. The requester drops `victim_req` in the cycle after it sees the grant.

Top module: `clock_victim_sel`

## Requirements
- R1: A synchronous, active-high reset clears every flag and places the hand at frame 0, so a request right after reset is granted in its first cycle with frame 0.
- R2: An access with `acc_valid` high raises the flag of frame `acc_frame` at the next edge. Accesses alone never assert `victim_gnt` and never move the hand (`victim_frame` stays unchanged).
- R3: While `victim_req` is high and the flag under the hand is raised, that flag is cleared, the hand advances by one frame, and no grant is given in that cycle.
- R4: While `victim_req` is high and the flag under the hand is low, `victim_gnt` is high in that same cycle and `victim_frame` equals the hand position. `victim_frame` presents the hand at all times.
- R5: After a grant, the hand points to the frame following the victim, and the victim's flag is raised.
- R6: If all NUM_FRAMES flags are raised when a request begins, the selector spends NUM_FRAMES cycles clearing them and grants, in cycle NUM_FRAMES (counted from 0), the frame where the hand started.
- R7: An access to the frame that the sweep is clearing in the same cycle wins, and the flag stays raised.
- R8: `clr_all` lowers every flag at the next edge, except a flag that an access or a victim load raises in that same cycle.
- R9: The hand wraps from frame NUM_FRAMES-1 to frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Strobe for an access to a resident frame |
| acc_frame | input | IDX_W | Frame index of the access |
| clr_all | input | 1 | Lowers all flags (periodic aging) |
| victim_req | input | 1 | Held high until a victim is granted |
| victim_gnt | output | 1 | High in the cycle the victim is found |
| victim_frame | output | IDX_W | Hand position; the victim while `victim_gnt` is high |

## Verification
The hardest situation to bring about is an access that lands on the exact frame the sweep is clearing, in that exact cycle. The bench creates it by first loading every flag through accesses, then raising the request and striking the frame under the hand in the request's first cycle. The sweep must then make a second full lap before it grants the following frame. Around this case, every one of the 256 flag patterns of the 8-frame pool is loaded and swept from whatever hand position the previous search left. This checks the wait length and the victim against an arithmetic model, including every wrap of the hand.

// File: rtl/clock_victim_pkg.sv
`timescale 1ns/1ps
package clock_victim_pkg;

    // Outcome of examining the frame under the hand
    typedef enum logic [1:0] {
        EXAM_NONE = 2'd0,
        EXAM_SKIP = 2'd1,
        EXAM_TAKE = 2'd2
    } exam_e;

    // Actions the decision stage hands to the storage and pointer
    typedef struct packed {
        logic grant;
        logic clr_cur;
        logic set_cur;
        logic step;
    } sweep_act_t;

    function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cv_refbits.sv
`timescale 1ns/1ps
module cv_refbits #(
    parameter int unsigned NUM_FRAMES = 8,
    parameter int unsigned IDX_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic [IDX_W-1:0]      acc_idx,
    input  logic                  clr_all,
    input  logic                  swp_clr,
    input  logic                  swp_set,
    input  logic [IDX_W-1:0]      swp_idx,
    output logic [NUM_FRAMES-1:0] bits
);

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        logic hit_acc;
        logic hit_swp;
        logic raise;
        logic lower;

        assign hit_acc = acc_valid && (acc_idx == IDX_W'(g));
        assign hit_swp = (swp_idx == IDX_W'(g));
        assign raise   = hit_acc || (swp_set && hit_swp);
        assign lower   = clr_all || (swp_clr && hit_swp);

        always_ff @(posedge clk) begin
            if (rst) begin
                bits[g] <= 1'b0;
            end else if (raise) begin
                bits[g] <= 1'b1;
            end else if (lower) begin
                bits[g] <= 1'b0;
            end
        end

        AST_ACCESS_WINS: assert property (@(posedge clk) disable iff (rst)
            (acc_valid && acc_idx == IDX_W'(g)) |=> bits[g]); // R7
    end

endmodule

// File: rtl/cv_hand.sv
`timescale 1ns/1ps
module cv_hand
    import clock_victim_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 8,
    parameter int unsigned IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] hand
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hand <= '0;
        end else if (step) begin
            hand <= IDX_W'(ring_next(32'(hand), NUM_FRAMES));
        end
    end

    AST_HAND_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && 32'(hand) == NUM_FRAMES - 1) |=> (hand == '0)); // R9

    AST_HAND_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(hand) < NUM_FRAMES); // R9

endmodule

// File: rtl/cv_decide.sv
`timescale 1ns/1ps
module cv_decide
    import clock_victim_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 8,
    parameter int unsigned IDX_W      = 3
) (
    input  logic                  req,
    input  logic [NUM_FRAMES-1:0] bits,
    input  logic [IDX_W-1:0]      hand,
    output sweep_act_t            act
);

    exam_e exam;

    always_comb begin
        if (!req) begin
            exam = EXAM_NONE;
        end else if (bits[hand]) begin
            exam = EXAM_SKIP;
        end else begin
            exam = EXAM_TAKE;
        end
    end

    always_comb begin
        act.grant   = (exam == EXAM_TAKE);
        act.set_cur = (exam == EXAM_TAKE);
        act.clr_cur = (exam == EXAM_SKIP);
        act.step    = (exam != EXAM_NONE);
    end

endmodule

// File: rtl/clock_victim_sel.sv
`timescale 1ns/1ps
module clock_victim_sel
    import clock_victim_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 8,
    localparam int unsigned IDX_W = idx_width(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             clr_all,
    input  logic             victim_req,
    output logic             victim_gnt,
    output logic [IDX_W-1:0] victim_frame
);

    logic [NUM_FRAMES-1:0] ref_bits;
    logic [IDX_W-1:0]      hand;
    sweep_act_t            act;

    cv_refbits #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_idx   (acc_frame),
        .clr_all   (clr_all),
        .swp_clr   (act.clr_cur),
        .swp_set   (act.set_cur),
        .swp_idx   (hand),
        .bits      (ref_bits)
    );

    cv_hand #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_hand (
        .clk  (clk),
        .rst  (rst),
        .step (act.step),
        .hand (hand)
    );

    cv_decide #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_decide (
        .req  (victim_req),
        .bits (ref_bits),
        .hand (hand),
        .act  (act)
    );

    assign victim_gnt   = act.grant;
    assign victim_frame = hand;

    AST_IDLE_HAND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !victim_req |=> $stable(victim_frame)); // R2

    AST_SEARCH_STEP: assert property (@(posedge clk) disable iff (rst)
        victim_req |=> victim_frame == IDX_W'(ring_next(32'($past(victim_frame)), NUM_FRAMES))); // R3

    AST_SKIP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (victim_req && !victim_gnt && !(acc_valid && acc_frame == victim_frame))
        |=> !ref_bits[$past(victim_frame)]); // R3

    AST_VICTIM_SET: assert property (@(posedge clk) disable iff (rst)
        victim_gnt |=> ref_bits[$past(victim_frame)]); // R5

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !acc_valid && !victim_gnt) |=> (ref_bits == '0)); // R8

endmodule

// File: tb/sim_clock_victim_sel.sv
`timescale 1ns/1ps
module sim_clock_victim_sel;

    localparam int N = 8;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         acc_valid = 1'b0;
    logic [W-1:0] acc_frame = '0;
    logic         clr_all = 1'b0;
    logic         vreq = 1'b0;
    logic         vgnt;
    logic [W-1:0] vframe;

    int           n_chk = 0;
    int           n_fail = 0;
    int           hand_m = 0;
    logic [N-1:0] bits_m = '0;

    always #2 clk = ~clk;

    clock_victim_sel #(.NUM_FRAMES(N)) u0 (
        .clk          (clk),
        .rst          (rst),
        .acc_valid    (acc_valid),
        .acc_frame    (acc_frame),
        .clr_all      (clr_all),
        .victim_req   (vreq),
        .victim_gnt   (vgnt),
        .victim_frame (vframe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Arithmetic model of one search from the requirements
    task automatic predict(output int cyc, output int frm);
        logic [N-1:0] b;
        bit found;
        b = bits_m;
        found = 0;
        cyc = 0;
        frm = hand_m;
        for (int i = 0; i < 2 * N; i++) begin
            int idx;
            idx = (hand_m + i) % N;
            if (!found) begin
                if (!b[idx]) begin
                    cyc = i;
                    frm = idx;
                    found = 1;
                end else begin
                    b[idx] = 1'b0;
                end
            end
        end
        b[frm] = 1'b1;
        bits_m = b;
        hand_m = (frm + 1) % N;
    endtask

    task automatic do_req(input int acc_first, output int cyc, output int frm);
        @(negedge clk);
        vreq = 1'b1;
        if (acc_first >= 0) begin
            acc_valid = 1'b1;
            acc_frame = W'(acc_first);
        end
        cyc = 0;
        frm = -1;
        for (int i = 0; i < 4 * N; i++) begin
            #1;
            if (vgnt) begin
                frm = int'(vframe);
                cyc = i;
                break;
            end
            @(negedge clk);
            acc_valid = 1'b0;
        end
        if (frm < 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 actual=no_grant expected=grant");
        end
        @(negedge clk);
        vreq = 1'b0;
        acc_valid = 1'b0;
    endtask

    task automatic set_pattern(input logic [N-1:0] p);
        @(negedge clk);
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
        for (int j = 0; j < N; j++) begin
            if (p[j]) begin
                acc_valid = 1'b1;
                acc_frame = W'(j);
                @(negedge clk);
            end
        end
        acc_valid = 1'b0;
        #1;
        chk("R2 hand unmoved by accesses", int'(vframe), hand_m);
        chk("R2 no grant from accesses", int'(vgnt), 0);
        bits_m = p;
    endtask

    task automatic run_and_check(input string req, input int acc_first);
        int ec, ef, ac, af, start;
        start = hand_m;
        predict(ec, ef);
        do_req(acc_first, ac, af);
        chk({req, " wait cycles"}, ac, ec);
        if (af < start) chk("R9 wrapped victim", af, ef);
        else            chk({req, " victim"}, af, ef);
        #1;
        chk("R5 hand after grant", int'(vframe), hand_m);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ac, af, h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 hand at reset", int'(vframe), 0);
        chk("R1 no grant at reset", int'(vgnt), 0);
        // R1: flags clear, so the very first request is granted at once with frame 0
        run_and_check("R1", -1);

        // R5 and R6: grant every frame once, then all flags are raised
        set_pattern('0);
        for (int k = 0; k < N; k++) run_and_check("R5", -1);
        h = hand_m;
        run_and_check("R6", -1);
        chk("R6 victim is start frame", (hand_m + N - 1) % N, h);

        // R7: access hits the frame under the hand in the first sweep cycle
        set_pattern('1);
        h = hand_m;
        do_req(h, ac, af);
        chk("R7 wait cycles", ac, N + 1);
        chk("R7 victim", af, (h + 1) % N);
        bits_m = '0;
        bits_m[af] = 1'b1;
        hand_m = (af + 1) % N;
        #1;
        chk("R7 hand after grant", int'(vframe), hand_m);

        // R8: clear-all together with an access to frame 3
        set_pattern('1);
        @(negedge clk);
        clr_all = 1'b1;
        acc_valid = 1'b1;
        acc_frame = W'(3);
        @(negedge clk);
        clr_all = 1'b0;
        acc_valid = 1'b0;
        bits_m = N'(1) << 3;
        run_and_check("R8", -1);

        // R3, R4, R9: every flag pattern, hand carried from the previous search
        for (int p = 0; p < (1 << N); p++) begin
            set_pattern(N'(p));
            run_and_check(p[0] ? "R3" : "R4", -1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule